// File: doc/BRIEF.md
# Line-Quality Error Counter Bank

This block collects line-quality error events for the performance-monitoring path of a T1/E1 framer. It has NB general 8-bit counters and one register byte that holds two independent 4-bit counters. One of the 4-bit counters counts out-of-frame events. The other counts frame-alignment moves after a resynchronization. Each counter takes a one-cycle pulse on its own bit of `ev_i`.

Software reaches the block through a simple synchronous register port. Through this port it reads any count, presets or zeroes a count by writing it, and masks the per-event and per-overflow interrupt sources. It also reads two clear-on-read flag registers: one holds event flags and the other holds overflows.

A global clear bit forces every counter to zero and holds it there. A sample-mode bit freezes the visible counts between one-second ticks. The one-second tick arrives as a pulse on `tick_i`. Event detection also happens outside this block.

Top module: `pm_errcnt_bank`

## Requirements
- R1: Byte counter i (register address i, for i in 0..NB-1) adds one for each cycle in which `ev_i[i]` is high. It wraps from 255 to 0.
- R2: A write to a counter address loads the written value into that counter. If an event for the same counter arrives in the same cycle, the written value wins and the event is not counted.
- R3: Register address NB holds two 4-bit counters:
  - bits [3:0] count `ev_i[NB]` (out-of-frame events);
  - bits [7:4] count `ev_i[NB+1]` (alignment changes);
  - each wraps from 15 to 0 on its own;
  - a write to this address presets both counters.
- R4: The overflow latch is at address NB+5. Its bit k (event index k) is set when counter k wraps. A read returns the latch and clears it. An overflow that happens in the same cycle as the read is kept set.
- R5: The event flag register is at address NB+4. Its bit k is set by each event on `ev_i[k]`. A read returns the register and clears it.
- R6: `irq_o` is registered. It is high one cycle after any bit of (event flags AND the event mask at NB+2) or (overflow latch AND the overflow mask at NB+3) is set, where a mask bit of 1 enables that source. When both masks are zero, `irq_o` stays low.
- R7: Control register at address NB+1, bit 0 (global clear): while this bit is 1, every counter reads 0, and both events and counter writes have no effect.
- R8: Control bit 1 (sample mode): while this bit is 1, the visible counts do not change between ticks. On a `tick_i` cycle, the visible count becomes the number of events gathered since the previous tick, including events in the tick cycle itself, and the gathering restarts from zero.
- R9: `reg_rdata` is registered. It shows the addressed register in the cycle after `reg_rd` is high. The control register reads back as {6'b0, sample, clear}.
- R10: After reset, every register reads zero and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_i | input | NB+2 | One-cycle error event pulses, one bit per counter |
| tick_i | input | 1 | One-second tick pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| irq_o | output | 1 | Combined interrupt, registered |

## Verification
Two pairs of functions can land on the same clock edge.

The first pair is a read of the overflow latch and a counter wrap. The bench presets a counter to 255, then drives its event pulse and the latch read in a single cycle. It checks that the read returns the old latch value, and that a second read shows the new bit.

The second pair is a counter write and an event for that counter. The bench drives both in one cycle and expects the written value, with the event dropped.

The bench also drives an event in the same cycle as a tick in sample mode. It expects that event to appear in the snapshot.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int DW = 8;
  localparam int NW = 4;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CNT, SEL_NIB, SEL_CTL, SEL_EVEN, SEL_OVEN, SEL_EVST, SEL_OVLT
  } sel_e;

  typedef struct packed {
    logic smp;
    logic clr;
  } ctl_t;
endpackage

// File: rtl/pm_counter.sv
module pm_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         smp,
  input  logic         tick,
  input  logic         ev,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] vis,
  output logic         wrap
);
  localparam logic [W-1:0] TOP = '1;
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] acc;
  logic [W-1:0] ev_w;

  assign ev_w = ev ? ONE : '0;

  always_comb begin
    if (clr)      wrap = 1'b0;
    else if (smp) wrap = ev && (acc == TOP);
    else          wrap = ev && !wr && (vis == TOP);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      vis <= '0;
      acc <= '0;
    end else if (smp) begin
      if (tick) begin
        acc <= '0;
        vis <= wr ? wdata : acc + ev_w;
      end else begin
        acc <= acc + ev_w;
        if (wr) vis <= wdata;
      end
    end else begin
      acc <= '0;
      if (wr)      vis <= wdata;
      else if (ev) vis <= vis + ONE;
    end
  end

  AST_CLR_HOLDS: assert property (@(posedge clk) disable iff (rst)
    clr |=> (vis == '0)); // R7
  AST_LIVE_INC: assert property (@(posedge clk) disable iff (rst)
    (!smp && !clr && ev && !wr) |=> (vis == $past(vis) + ONE)); // R1
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    (!smp && !clr && wr) |=> (vis == $past(wdata))); // R2
  AST_SAMPLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (smp && !clr && !tick && !wr) |=> $stable(vis)); // R8
endmodule

// File: rtl/pm_sticky.sv
module pm_sticky #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd_clr,
  input  logic [N-1:0] set,
  output logic [N-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (rd_clr ? '0 : q) | set;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (|set) |=> ((q & $past(set)) == $past(set))); // R4
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && set == '0) |=> (q == '0)); // R5
endmodule

// File: rtl/pm_errcnt_bank.sv
module pm_errcnt_bank
  import pm_pkg::*;
#(
  parameter int NB = 3,
  parameter int AW = 4,
  localparam int NE = NB + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NE-1:0] ev_i,
  input  logic          tick_i,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq_o
);
  localparam int A_NIB  = NB;
  localparam int A_CTL  = NB + 1;
  localparam int A_EVEN = NB + 2;
  localparam int A_OVEN = NB + 3;
  localparam int A_EVST = NB + 4;
  localparam int A_OVLT = NB + 5;

  sel_e          sel;
  ctl_t          ctl_q;
  logic [NE-1:0] ev_en, ov_en, ev_st, ov_lt, wrap_v;
  logic [DW-1:0] cnt_vis [NB];
  logic [NW-1:0] oof_vis, ra_vis;
  logic [DW-1:0] rd_mux;

  always_comb begin
    int a;
    a = int'(reg_addr);
    if (a < NB)            sel = SEL_CNT;
    else if (a == A_NIB)   sel = SEL_NIB;
    else if (a == A_CTL)   sel = SEL_CTL;
    else if (a == A_EVEN)  sel = SEL_EVEN;
    else if (a == A_OVEN)  sel = SEL_OVEN;
    else if (a == A_EVST)  sel = SEL_EVST;
    else if (a == A_OVLT)  sel = SEL_OVLT;
    else                   sel = SEL_NONE;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NB; gi++) begin : g_byte
      pm_counter #(.W(DW)) u_cnt (
        .clk(clk), .rst(rst), .clr(ctl_q.clr), .smp(ctl_q.smp), .tick(tick_i),
        .ev(ev_i[gi]),
        .wr(reg_wr && sel == SEL_CNT && int'(reg_addr) == gi),
        .wdata(reg_wdata), .vis(cnt_vis[gi]), .wrap(wrap_v[gi])
      );
    end
  endgenerate

  pm_counter #(.W(NW)) u_oof (
    .clk(clk), .rst(rst), .clr(ctl_q.clr), .smp(ctl_q.smp), .tick(tick_i),
    .ev(ev_i[NB]), .wr(reg_wr && sel == SEL_NIB),
    .wdata(reg_wdata[NW-1:0]), .vis(oof_vis), .wrap(wrap_v[NB])
  );

  pm_counter #(.W(NW)) u_realign (
    .clk(clk), .rst(rst), .clr(ctl_q.clr), .smp(ctl_q.smp), .tick(tick_i),
    .ev(ev_i[NB+1]), .wr(reg_wr && sel == SEL_NIB),
    .wdata(reg_wdata[DW-1:NW]), .vis(ra_vis), .wrap(wrap_v[NB+1])
  );

  pm_sticky #(.N(NE)) u_evst (
    .clk(clk), .rst(rst), .rd_clr(reg_rd && sel == SEL_EVST),
    .set(ev_i), .q(ev_st)
  );

  pm_sticky #(.N(NE)) u_ovlt (
    .clk(clk), .rst(rst), .rd_clr(reg_rd && sel == SEL_OVLT),
    .set(wrap_v), .q(ov_lt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      ev_en <= '0;
      ov_en <= '0;
    end else if (reg_wr) begin
      if (sel == SEL_CTL)  ctl_q <= ctl_t'(reg_wdata[1:0]);
      if (sel == SEL_EVEN) ev_en <= reg_wdata[NE-1:0];
      if (sel == SEL_OVEN) ov_en <= reg_wdata[NE-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_CNT: begin
        for (int k = 0; k < NB; k++)
          if (int'(reg_addr) == k) rd_mux = cnt_vis[k];
      end
      SEL_NIB:  rd_mux = {ra_vis, oof_vis};
      SEL_CTL:  rd_mux = DW'(ctl_q);
      SEL_EVEN: rd_mux = DW'(ev_en);
      SEL_OVEN: rd_mux = DW'(ov_en);
      SEL_EVST: rd_mux = DW'(ev_st);
      SEL_OVLT: rd_mux = DW'(ov_lt);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq_o     <= 1'b0;
    end else begin
      if (reg_rd) reg_rdata <= rd_mux;
      irq_o <= (|(ev_st & ev_en)) || (|(ov_lt & ov_en));
    end
  end

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (ev_en == '0 && ov_en == '0) |=> !irq_o); // R6
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
    (|(ov_lt & ov_en)) |=> irq_o); // R6
endmodule

// File: tb/tb_pm_errcnt_bank.sv
module tb_pm_errcnt_bank;
  localparam int NB = 3;
  localparam int NE = NB + 2;
  localparam logic [3:0] A_NIB = 4'd3, A_CTL = 4'd4, A_EVEN = 4'd5,
                         A_OVEN = 4'd6, A_EVST = 4'd7, A_OVLT = 4'd8;

  logic clk = 0, rst = 1, tick = 0, wr = 0, rd = 0;
  logic [NE-1:0] ev = '0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic irq;
  int nchk = 0, nbad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pm_errcnt_bank #(.NB(NB), .AW(4)) dut (
    .clk(clk), .rst(rst), .ev_i(ev), .tick_i(tick), .reg_wr(wr), .reg_rd(rd),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input int got, input int exp);
    nchk++;
    if (got != exp) begin
      nbad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wreg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic rreg(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); rd = 1; addr = a;
    @(negedge clk); rd = 0; d = rdata;
  endtask

  task automatic pulse(input logic [NE-1:0] m, input logic t);
    @(negedge clk); ev = m; tick = t;
    @(negedge clk); ev = '0; tick = 0;
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    // R10: reset state
    for (int a = 0; a <= 8; a++) begin
      rreg(4'(a), d); chk("R10 reset reg", d, 0);
    end
    chk("R10 irq", irq, 0);

    // R1: sweep every byte counter across its wrap
    for (int k = 0; k < NB; k++) begin
      rreg(4'(k), d); chk("R1 start", d, 0);
      for (int n = 1; n <= 260; n++) begin
        pulse(NE'(1 << k), 0);
        rreg(4'(k), d); chk("R1 count", d, n % 256);
      end
      rreg(A_OVLT, d); chk("R4 wrap latched", d, 1 << k);
      rreg(A_OVLT, d); chk("R4 cleared on read", d, 0);
    end

    // R2: preset then wrap
    wreg(4'd1, 8'hFE);
    rreg(4'd1, d); chk("R2 preset", d, 8'hFE);
    pulse(5'b00010, 0); pulse(5'b00010, 0);
    rreg(4'd1, d); chk("R2 preset wrap", d, 0);
    rreg(A_OVLT, d); chk("R4 preset wrap", d, 8'h02);

    // R3: nibble pair
    for (int n = 1; n <= 17; n++) begin
      pulse(5'b01000, 0);
      rreg(A_NIB, d); chk("R3 oof", d, n % 16);
    end
    for (int n = 1; n <= 5; n++) pulse(5'b10000, 0);
    rreg(A_NIB, d); chk("R3 realign", d, 8'h51);
    rreg(A_OVLT, d); chk("R3 oof wrap latched", d, 8'h08);
    wreg(A_NIB, 8'hA5);
    rreg(A_NIB, d); chk("R3 preset", d, 8'hA5);

    // R5/R6: event flags and irq
    rreg(A_EVST, d);
    wreg(A_EVEN, 8'h01);
    pulse(5'b00001, 0);
    @(negedge clk); chk("R6 irq on event", irq, 1);
    rreg(A_EVST, d); chk("R5 flag read", d, 8'h01);
    @(negedge clk); chk("R6 irq drops", irq, 0);
    wreg(A_EVEN, 8'h00);
    pulse(5'b00010, 0);
    @(negedge clk); @(negedge clk); chk("R6 masked irq", irq, 0);
    rreg(A_EVST, d); chk("R5 masked flag", d, 8'h02);
    rreg(A_EVST, d); chk("R5 cleared", d, 0);
    wreg(4'd0, 8'hFF); wreg(A_OVEN, 8'h01);
    pulse(5'b00001, 0);
    @(negedge clk); @(negedge clk); chk("R6 irq on overflow", irq, 1);
    rreg(A_OVLT, d); chk("R4 ovf read", d, 8'h01);
    @(negedge clk); chk("R6 ovf irq drops", irq, 0);
    wreg(A_OVEN, 8'h00);

    // R4: overflow in same cycle as latch read
    wreg(4'd2, 8'hFF);
    @(negedge clk); ev = 5'b00100; rd = 1; addr = A_OVLT;
    @(negedge clk); ev = '0; rd = 0; d = rdata;
    chk("R4 read during wrap returns old", d, 0);
    rreg(A_OVLT, d); chk("R4 new bit kept", d, 8'h04);
    // R2: write and event in the same cycle
    @(negedge clk); wr = 1; addr = 4'd1; wdata = 8'h40; ev = 5'b00010;
    @(negedge clk); wr = 0; ev = '0;
    rreg(4'd1, d); chk("R2 write beats event", d, 8'h40);

    // R7: global clear
    wreg(A_CTL, 8'h01);
    rreg(A_CTL, d); chk("R9 ctl readback", d, 8'h01);
    pulse(5'b11111, 0);
    rreg(4'd0, d); chk("R7 cleared", d, 0);
    wreg(4'd0, 8'h33);
    rreg(4'd0, d); chk("R7 write ignored", d, 0);
    rreg(A_NIB, d); chk("R7 nibbles cleared", d, 0);
    rreg(A_OVLT, d); chk("R7 no overflow", d, 0);
    wreg(A_CTL, 8'h00);

    // R8: sample mode
    wreg(A_CTL, 8'h02);
    wreg(4'd0, 8'h07);
    for (int n = 0; n < 5; n++) pulse(5'b00001, 0);
    rreg(4'd0, d); chk("R8 held between ticks", d, 7);
    pulse('0, 1);
    rreg(4'd0, d); chk("R8 snapshot", d, 5);
    pulse(5'b00001, 0); pulse(5'b00001, 0); pulse(5'b00001, 1);
    rreg(4'd0, d); chk("R8 tick-cycle event included", d, 3);
    pulse('0, 1);
    rreg(4'd0, d); chk("R8 accumulator restarted", d, 0);
    wreg(A_CTL, 8'h00);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end
endmodule